// File: doc/BRIEF.md
# Watchdog Timer with Expiry Action Select

This block counts prescaled clock ticks while software keeps it armed. If software does not restart the count in time, the count reaches a programmed terminal value, and the block then signals one of two outcomes. A single field chooses the outcome. It is either a sticky non-maskable interrupt request that can be masked, or a one-cycle master reset request that cannot be masked. The reset generator and the exception handling downstream are not part of the block.

Software sees five word registers through a simple register port. Reads return data one cycle after the read strobe. The five registers are:
- a control word that holds the run bit and the watchdog-mode bit;
- a mode word that holds the action select and the interrupt enable, plus two self-clearing command bits (restart and leave-watchdog-mode);
- the terminal count;
- a status word with the write-one-to-clear expiry flag;
- a read-only view of the live count.

Top module: `expiry_watchdog`

## Requirements
- R1: After reset, the control, mode and status words read 0, the terminal count reads all ones, and `nmi_req` and `mrst_req` are low.
- R2: The word addresses are: control at 0 (bit 0 run, bit 1 watchdog mode), mode at 1 (bit 16 action select, bit 15 interrupt enable), terminal count at 2, status at 3 (bit 0 expiry flag) and live count at 4. `rd_data` presents the addressed word in the cycle after `rd_en`.
- R3: Every bit that no field defines reads back as 0, and a write of 1 to such a bit has no effect.
- R4: The count advances by one every PRESCALE clocks, but only while the run bit and the watchdog-mode bit are both 1. The block expires on the tick where the advanced value would equal the terminal count. On that tick the count restarts at 0.
- R5: Writing 1 to mode bit 0 sets the count and the prescaler to 0 at that clock edge. The bit always reads 0, and writing 0 to it does nothing.
- R6: Writing 1 to mode bit 7 clears both the run bit and the watchdog-mode bit, so the count freezes. The bit always reads 0, and writing 0 to it does nothing.
- R7: An expiry with action select 0 sets the sticky expiry flag. `nmi_req` equals the flag ANDed with the interrupt enable, so masking hides the request but leaves the flag intact.
- R8: Writing 1 to status bit 0 clears the flag. If an expiry arrives in the same cycle, the set takes priority.
- R9: An expiry with action select 1 drives `mrst_req` high for the single cycle after the expiry, whatever the interrupt enable holds, and leaves the flag unchanged.
- R10: If a restart command arrives in the same cycle as the terminal tick, the restart wins: no flag, no reset request, and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| nmi_req | output | 1 | Masked non-maskable interrupt request (level) |
| mrst_req | output | 1 | Master reset request (one-cycle pulse) |

## Verification
The hardest case to reach is a restart command that lands in exactly the cycle that carries the terminal tick. It is only reachable if the edge is known to the clock. The bench first sets the count and the prescaler to zero with the block stopped. It then arms the block with a small terminal count and a prescaler of two, counts the cycles of the expected expiry from the arming write, and issues the restart write so that it takes effect on that exact edge. Afterwards it checks that the flag, both request outputs and the live count show that the expiry never happened.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int REG_W = 32;

   // word addresses
   localparam int unsigned ADR_CTRL = 0;
   localparam int unsigned ADR_MODE = 1;
   localparam int unsigned ADR_TERM = 2;
   localparam int unsigned ADR_STAT = 3;
   localparam int unsigned ADR_CNT  = 4;

   // bit positions
   localparam int CTRL_RUN_B = 0;
   localparam int CTRL_WDM_B = 1;
   localparam int MODE_ACT_B = 16;
   localparam int MODE_IE_B  = 15;
   localparam int MODE_DIS_B = 7;
   localparam int MODE_CLR_B = 0;
   localparam int STAT_FLG_B = 0;

   typedef struct packed {
      logic wd_mode;
      logic run;
   } ctrl_t;

   typedef struct packed {
      logic act_rst;
      logic irq_en;
   } mode_t;

endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W    = 32,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             clr,
   input  logic [CNT_W-1:0] term,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   logic             tick;
   logic [CNT_W-1:0] cnt_nx;
   logic             hit;

   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre <= '0;
            else if (clr)
               pre <= '0;
            else if (active)
               pre <= (pre == PLAST) ? '0 : pre + 1'b1;
         end
         assign tick = active && (pre == PLAST);
      end
   endgenerate

   assign cnt_nx = cnt + CNT_W'(1);
   assign hit    = tick && (cnt_nx == term);
   assign expire = hit && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (tick)
         cnt <= hit ? '0 : cnt_nx;
   end

endmodule

// File: rtl/wdog_event.sv
module wdog_event (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic act_rst,
   input  logic irq_en,
   input  logic flag_w1c,
   output logic flag,
   output logic nmi_req,
   output logic mrst_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag     <= 1'b0;
         mrst_req <= 1'b0;
      end else begin
         if (expire && !act_rst)
            flag <= 1'b1;
         else if (flag_w1c)
            flag <= 1'b0;
         mrst_req <= expire && act_rst;
      end
   end

   assign nmi_req = flag && irq_en;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              flag,
   input  logic [CNT_W-1:0]  cnt,
   output ctrl_t             ctrl,
   output mode_t             mode,
   output logic [CNT_W-1:0]  term,
   output logic              clr_cmd,
   output logic              dis_cmd,
   output logic              flag_w1c,
   output logic [REG_W-1:0]  rd_data
);

   logic             sel_ctrl, sel_mode, sel_term, sel_stat, sel_cnt;
   logic [REG_W-1:0] rd_mux;
   logic             unused_wbits;

   assign sel_ctrl = (addr == ADDR_W'(ADR_CTRL));
   assign sel_mode = (addr == ADDR_W'(ADR_MODE));
   assign sel_term = (addr == ADDR_W'(ADR_TERM));
   assign sel_stat = (addr == ADDR_W'(ADR_STAT));
   assign sel_cnt  = (addr == ADDR_W'(ADR_CNT));

   assign clr_cmd  = wr_en && sel_mode && wr_data[MODE_CLR_B];
   assign dis_cmd  = wr_en && sel_mode && wr_data[MODE_DIS_B];
   assign flag_w1c = wr_en && sel_stat && wr_data[STAT_FLG_B];
   assign unused_wbits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         mode <= '0;
         term <= '1;
      end else begin
         if (dis_cmd)
            ctrl <= '0;
         else if (wr_en && sel_ctrl) begin
            ctrl.run     <= wr_data[CTRL_RUN_B];
            ctrl.wd_mode <= wr_data[CTRL_WDM_B];
         end
         if (wr_en && sel_mode) begin
            mode.act_rst <= wr_data[MODE_ACT_B];
            mode.irq_en  <= wr_data[MODE_IE_B];
         end
         if (wr_en && sel_term)
            term <= wr_data[CNT_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel_ctrl) begin
         rd_mux[CTRL_RUN_B] = ctrl.run;
         rd_mux[CTRL_WDM_B] = ctrl.wd_mode;
      end else if (sel_mode) begin
         rd_mux[MODE_ACT_B] = mode.act_rst;
         rd_mux[MODE_IE_B]  = mode.irq_en;
      end else if (sel_term) begin
         rd_mux = REG_W'(term);
      end else if (sel_stat) begin
         rd_mux[STAT_FLG_B] = flag;
      end else if (sel_cnt) begin
         rd_mux = REG_W'(cnt);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end

endmodule

// File: rtl/expiry_watchdog.sv
module expiry_watchdog
   import wdog_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int CNT_W    = 32,
   parameter int PRESCALE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              nmi_req,
   output logic              mrst_req
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $fatal(1, "ADDR_W must cover five word addresses");
      end
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
         $fatal(1, "CNT_W must lie between 2 and the register width");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $fatal(1, "PRESCALE must be at least 1");
      end
   endgenerate

   ctrl_t            ctrl_q;
   mode_t            mode_q;
   logic [CNT_W-1:0] term_q;
   logic [CNT_W-1:0] cnt_q;
   logic             clr_cmd, dis_cmd, flag_w1c;
   logic             flag_q, expire, active;

   assign active = ctrl_q.run && ctrl_q.wd_mode;

   wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .flag     (flag_q),
      .cnt      (cnt_q),
      .ctrl     (ctrl_q),
      .mode     (mode_q),
      .term     (term_q),
      .clr_cmd  (clr_cmd),
      .dis_cmd  (dis_cmd),
      .flag_w1c (flag_w1c),
      .rd_data  (rd_data)
   );

   wdog_count #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .clr    (clr_cmd),
      .term   (term_q),
      .cnt    (cnt_q),
      .expire (expire)
   );

   wdog_event u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .act_rst  (mode_q.act_rst),
      .irq_en   (mode_q.irq_en),
      .flag_w1c (flag_w1c),
      .flag     (flag_q),
      .nmi_req  (nmi_req),
      .mrst_req (mrst_req)
   );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
   input logic clk,
   input logic rst_n,
   input logic nmi_req,
   input logic mrst_req,
   input logic irq_en,
   input logic act_rst,
   input logic flag,
   input logic clr_cmd,
   input logic dis_cmd,
   input logic run,
   input logic wd_mode,
   input logic expire
);

   // R6
   dis_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> (!run && !wd_mode));

   // R7
   nmi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> irq_en);

   // R9
   mrst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mrst_req |-> $past(expire && act_rst));

   // R9
   mrst_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && act_rst && !flag) |=> !flag);

   // R10
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |-> !expire);

   // R10
   clear_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> !mrst_req);

endmodule

bind expiry_watchdog wdog_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .nmi_req  (nmi_req),
   .mrst_req (mrst_req),
   .irq_en   (mode_q.irq_en),
   .act_rst  (mode_q.act_rst),
   .flag     (flag_q),
   .clr_cmd  (clr_cmd),
   .dis_cmd  (dis_cmd),
   .run      (ctrl_q.run),
   .wd_mode  (ctrl_q.wd_mode),
   .expire   (expire)
);

// File: tb/sim_expiry_watchdog.sv
`timescale 1ns/1ps
module sim_expiry_watchdog;

   localparam int AW = 3;
   localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_TERM = 3'd2,
                          A_STAT = 3'd3, A_CNT = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic          nmi_req, mrst_req;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   expiry_watchdog #(.ADDR_W(AW), .CNT_W(32), .PRESCALE(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .nmi_req(nmi_req), .mrst_req(mrst_req)
   );

   localparam int NV = 10;
   localparam logic [2:0]  VWA [NV] = '{A_MODE, A_CTRL, A_MODE, A_MODE, A_MODE,
                                        A_TERM, A_CTRL, A_MODE, A_MODE, A_STAT};
   localparam logic [31:0] VWD [NV] = '{32'hFFFF_FFFF, 32'h3, 32'h0, 32'h80, 32'h80,
                                        32'h1234_5678, 32'hFFFF_FFFF, 32'h0001_0000,
                                        32'h0000_8001, 32'hFFFF_FFFE};
   localparam logic [2:0]  VRA [NV] = '{A_MODE, A_CTRL, A_CTRL, A_CTRL, A_MODE,
                                        A_TERM, A_CTRL, A_MODE, A_MODE, A_STAT};
   localparam logic [31:0] VEX [NV] = '{32'h0001_8000, 32'h3, 32'h3, 32'h0, 32'h0,
                                        32'h1234_5678, 32'h3, 32'h0001_0000,
                                        32'h0000_8000, 32'h0};
   localparam string VRQ [NV] = '{"R3", "R2", "R6", "R6", "R6",
                                  "R2", "R3", "R2", "R5", "R3"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      d = rd_data;
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v, c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 nmi", {31'b0, nmi_req}, 32'h0);
      check("R1 mrst", {31'b0, mrst_req}, 32'h0);
      rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
      rd(A_MODE, v); check("R1 mode", v, 32'h0);
      rd(A_STAT, v); check("R1 stat", v, 32'h0);
      rd(A_TERM, v); check("R1 term", v, 32'hFFFF_FFFF);

      // vector table: write, then read back
      for (int i = 0; i < NV; i++) begin
         wr(VWA[i], VWD[i]);
         rd(VRA[i], v);
         check(VRQ[i], v, VEX[i]);
      end
      wr(A_CTRL, 32'h0);

      // R4 / R7: NMI expiry timing, terminal 5, prescale 2 -> 10 cycles
      wr(A_STAT, 32'h1);
      wr(A_TERM, 32'd5);
      wr(A_MODE, 32'h0000_8001);
      wr(A_CTRL, 32'h3);
      repeat (9) @(negedge clk);
      check("R4 nmi before terminal", {31'b0, nmi_req}, 32'h0);
      @(negedge clk);
      check("R7 nmi at expiry", {31'b0, nmi_req}, 32'h1);
      check("R7 no mrst", {31'b0, mrst_req}, 32'h0);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, v); check("R4 restart at 0", v, 32'h0);
      rd(A_STAT, v); check("R7 flag set", v, 32'h1);
      wr(A_MODE, 32'h0);
      check("R7 masked", {31'b0, nmi_req}, 32'h0);
      rd(A_STAT, v); check("R7 flag sticky under mask", v, 32'h1);
      wr(A_MODE, 32'h0000_8000);
      check("R7 unmasked", {31'b0, nmi_req}, 32'h1);
      wr(A_STAT, 32'h1);
      check("R8 nmi after w1c", {31'b0, nmi_req}, 32'h0);
      rd(A_STAT, v); check("R8 flag cleared", v, 32'h0);

      // R9: reset request, terminal 3 -> 6 cycles, irq enabled yet no NMI
      wr(A_TERM, 32'd3);
      wr(A_MODE, 32'h0001_8001);
      wr(A_CTRL, 32'h3);
      repeat (5) @(negedge clk);
      check("R9 mrst before", {31'b0, mrst_req}, 32'h0);
      @(negedge clk);
      check("R9 mrst pulse", {31'b0, mrst_req}, 32'h1);
      @(negedge clk);
      check("R9 mrst one cycle", {31'b0, mrst_req}, 32'h0);
      wr(A_CTRL, 32'h0);
      check("R9 no nmi", {31'b0, nmi_req}, 32'h0);
      rd(A_STAT, v); check("R9 flag untouched", v, 32'h0);

      // R10: restart lands on the terminal tick
      wr(A_TERM, 32'd5);
      wr(A_MODE, 32'h0000_8001);
      wr(A_CTRL, 32'h3);
      repeat (9) @(negedge clk);
      wr(A_MODE, 32'h0000_8001);
      check("R10 no nmi", {31'b0, nmi_req}, 32'h0);
      check("R10 no mrst", {31'b0, mrst_req}, 32'h0);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, v); check("R10 count zero", v, 32'h0);
      rd(A_STAT, v); check("R10 flag clear", v, 32'h0);

      // R6 / R4: disable mid-count freezes the count
      wr(A_TERM, 32'hFFFF_FFFF);
      wr(A_MODE, 32'h1);
      wr(A_CTRL, 32'h3);
      repeat (20) @(negedge clk);
      wr(A_MODE, 32'h80);
      rd(A_CNT, c1); check("R4 rate", c1, 32'd10);
      repeat (10) @(negedge clk);
      rd(A_CNT, v); check("R6 frozen", v, c1);
      rd(A_CTRL, v); check("R6 ctrl cleared", v, 32'h0);

      // R5: clear zeroes a nonzero count
      wr(A_CTRL, 32'h3);
      repeat (6) @(negedge clk);
      wr(A_MODE, 32'h1);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, v); check("R5 count cleared", v, 32'h0);
      wr(A_MODE, 32'h0);
      rd(A_CNT, v); check("R5 write 0 no effect", v, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule